// File: doc/BRIEF.md
# Eight-bit Arithmetic Logic Unit with Extended Status Flags

This block is a purely combinational arithmetic-logic unit for an eight-bit datapath. Each cycle it takes two byte operands, a carry input and a four-bit operation code. It returns a low result byte, a high result byte and a set of status flags. The sixteen operations cover:

- bitwise logic
- unsigned, signed and carry-chained addition
- unsigned subtraction with borrow
- signed and unsigned multiplication with a sixteen-bit product
- rotates and shifts
- conversion of four packed decimal digits to binary

Besides the usual zero, carry, overflow and negative indications, the unit reports whether the low result byte is a bit-palindrome and whether it is a prime number. It also gives a summary flag that is the OR of zero, carry and overflow. The unit holds no state, so a surrounding datapath can register its inputs or outputs wherever timing demands it.

Top module: `alu8_xflag`

## Requirements
- R1: Opcodes 0000, 0001, 0010 and 0011 give AND, OR, XOR and XNOR of the two operands on the low byte.
- R2: Opcode 0100 gives the nine-bit sum {carry_o, lo_o} = lhs + rhs. Opcode 0110 gives {carry_o, lo_o} = lhs + rhs + carry_i.
- R3: Opcode 0101 gives lo_o = lhs + rhs modulo 256. ovf_o is high when the two operands share a sign and the result sign differs. neg_o equals bit 7 of lo_o.
- R4: Opcode 1001 gives lo_o = lhs - rhs modulo 256, and carry_o is high exactly when lhs < rhs (a borrow).
- R5: Opcode 1000 gives the unsigned product and opcode 0111 the two's-complement product, with {hi_o, lo_o} holding all 16 bits. For 0111, ovf_o is high when the product lies outside -128..127, and neg_o is bit 15 of the product.
- R6: Opcode 1010 rotates lhs left by one with carry_o low. Opcode 1011 rotates the nine-bit value {carry_i, lhs} left by one: lo_o = {lhs[6:0], carry_i} and carry_o = lhs[7].
- R7: Shift opcodes:
  - 1100 shifts lhs right logically, with carry_o = lhs[0].
  - 1101 shifts lhs right arithmetically, with carry_o = lhs[0] and neg_o = bit 7 of the result.
  - 1110 shifts lhs left logically, with carry_o = lhs[7].
- R8: Opcode 1111 reads {rhs, lhs} as four four-bit decimal digits, with rhs[7:4] the most significant. It returns 1000*d3 + 100*d2 + 10*d1 + d0 on {hi_o, lo_o}, and applies the same arithmetic to digit codes above 9.
- R9: hi_o is zero for every opcode other than 0111, 1000 and 1111.
- R10: zero_o is high when {hi_o, lo_o} is zero. For single-byte opcodes this equals lo_o being zero.
- R11: Where each flag may be high:
  - ovf_o may be high only for opcodes 0101 and 0111.
  - carry_o may be high only for 0100, 0110, 1001, 1011, 1100, 1101 and 1110.
  - neg_o may be high only for 0101, 0111 and 1101.
- R12: any_o equals zero_o OR carry_o OR ovf_o.
- R13: pal_o is high when lo_o equals itself with its eight bits reversed.
- R14: prime_o is high when lo_o, read as an unsigned number from 0 to 255, is prime. Values 0 and 1 are not prime.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lhs_i | input | 8 | First operand; low decimal digits for opcode 1111 |
| rhs_i | input | 8 | Second operand; high decimal digits for opcode 1111 |
| carry_i | input | 1 | Carry input for add-with-carry and rotate-through-carry |
| opcode_i | input | 4 | Operation select |
| lo_o | output | 8 | Result byte, or low byte of a 16-bit result |
| hi_o | output | 8 | High byte of a 16-bit result, otherwise zero |
| zero_o | output | 1 | Result is zero |
| carry_o | output | 1 | Carry, borrow or shifted-out bit |
| ovf_o | output | 1 | Signed overflow |
| any_o | output | 1 | OR of zero, carry and overflow |
| neg_o | output | 1 | Sign of the signed result |
| pal_o | output | 1 | Low result byte is a bit-palindrome |
| prime_o | output | 1 | Low result byte is prime |

## Verification
All results and flags are combinational, so each output is due in the same cycle as its operands, with no register on the way. The driver applies a stimulus at a rising edge and queues the expected result. The monitor pops that result and compares it at the next falling edge, half a period later, when the inputs have been stable for 4 ns. The queue never holds more than one entry. Every byte value passes through the palindrome and prime detectors exhaustively, and each opcode is hit with directed corner operands and then random ones.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW     = 8;
    localparam int PW     = 2 * DW;
    localparam int NDIG   = PW / 4;

    typedef enum logic [3:0] {
        OP_AND  = 4'h0, OP_OR   = 4'h1, OP_XOR  = 4'h2, OP_XNOR = 4'h3,
        OP_ADDU = 4'h4, OP_ADDS = 4'h5, OP_ADDC = 4'h6, OP_MULS = 4'h7,
        OP_MULU = 4'h8, OP_SUBU = 4'h9, OP_ROL  = 4'hA, OP_RLC  = 4'hB,
        OP_LSR  = 4'hC, OP_ASR  = 4'hD, OP_LSL  = 4'hE, OP_BCD  = 4'hF
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
        logic          carry;
        logic          ovf;
        logic          neg;
    } alu_res_t;
endpackage

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
(
    input  logic [1:0]    fn_i,
    input  logic [DW-1:0] lhs_i,
    input  logic [DW-1:0] rhs_i,
    output logic [DW-1:0] lo_o
);
    always_comb begin
        case (fn_i)
            2'd0:    lo_o = lhs_i & rhs_i;
            2'd1:    lo_o = lhs_i | rhs_i;
            2'd2:    lo_o = lhs_i ^ rhs_i;
            default: lo_o = ~(lhs_i ^ rhs_i);
        endcase
    end
endmodule

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
(
    input  alu_op_e       op_i,
    input  logic [DW-1:0] lhs_i,
    input  logic [DW-1:0] rhs_i,
    input  logic          carry_i,
    output alu_res_t      res_o
);
    logic [DW:0]          sum_d;
    logic [DW:0]          diff_d;
    logic [PW-1:0]        prod_u_d;
    logic signed [PW-1:0] prod_s_d;
    logic [DW:0]          cin_ext;

    always_comb begin
        cin_ext  = {{DW{1'b0}}, (op_i == OP_ADDC) ? carry_i : 1'b0};
        sum_d    = {1'b0, lhs_i} + {1'b0, rhs_i} + cin_ext;
        diff_d   = {1'b0, lhs_i} - {1'b0, rhs_i};
        prod_u_d = PW'(lhs_i) * PW'(rhs_i);
        prod_s_d = PW'($signed(lhs_i)) * PW'($signed(rhs_i));
        res_o    = '0;
        case (op_i)
            OP_ADDU, OP_ADDC: begin
                res_o.lo    = sum_d[DW-1:0];
                res_o.carry = sum_d[DW];
            end
            OP_ADDS: begin
                res_o.lo  = sum_d[DW-1:0];
                res_o.ovf = (lhs_i[DW-1] == rhs_i[DW-1]) && (sum_d[DW-1] != lhs_i[DW-1]);
                res_o.neg = sum_d[DW-1];
            end
            OP_SUBU: begin
                res_o.lo    = diff_d[DW-1:0];
                res_o.carry = diff_d[DW];
            end
            OP_MULU: {res_o.hi, res_o.lo} = prod_u_d;
            OP_MULS: begin
                {res_o.hi, res_o.lo} = prod_s_d;
                res_o.ovf = !((&prod_s_d[PW-1:DW-1]) || (~|prod_s_d[PW-1:DW-1]));
                res_o.neg = prod_s_d[PW-1];
            end
            default: res_o = '0;
        endcase

        if (!$isunknown({op_i, lhs_i, rhs_i, carry_i})) begin
            if (op_i == OP_SUBU)
                assert_sub_borrow_R4: assert (res_o.carry == (res_o.lo > lhs_i))
                    else $error("borrow disagrees with wrapped difference");
            if (op_i == OP_ADDU)
                assert_add_carry_R2: assert (res_o.carry == (res_o.lo < lhs_i))
                    else $error("carry disagrees with wrapped sum");
            if ((op_i == OP_MULU) && (lhs_i == '0 || rhs_i == '0))
                assert_mul_zero_R5: assert ({res_o.hi, res_o.lo} == '0)
                    else $error("product of zero operand is nonzero");
        end
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
(
    input  alu_op_e       op_i,
    input  logic [DW-1:0] lhs_i,
    input  logic          carry_i,
    output alu_res_t      res_o
);
    always_comb begin
        res_o = '0;
        case (op_i)
            OP_ROL: res_o.lo = {lhs_i[DW-2:0], lhs_i[DW-1]};
            OP_RLC: begin
                res_o.lo    = {lhs_i[DW-2:0], carry_i};
                res_o.carry = lhs_i[DW-1];
            end
            OP_LSR: begin
                res_o.lo    = {1'b0, lhs_i[DW-1:1]};
                res_o.carry = lhs_i[0];
            end
            OP_ASR: begin
                res_o.lo    = {lhs_i[DW-1], lhs_i[DW-1:1]};
                res_o.carry = lhs_i[0];
                res_o.neg   = lhs_i[DW-1];
            end
            OP_LSL: begin
                res_o.lo    = {lhs_i[DW-2:0], 1'b0};
                res_o.carry = lhs_i[DW-1];
            end
            default: res_o = '0;
        endcase

        if (!$isunknown({op_i, lhs_i, carry_i})) begin
            if (op_i == OP_LSR)
                assert_lsr_fill_R7: assert (res_o.lo[DW-1] == 1'b0 && !res_o.neg)
                    else $error("logical right shift filled a one");
            if (op_i == OP_ASR)
                assert_asr_sign_R7: assert (res_o.lo[DW-1] == lhs_i[DW-1])
                    else $error("arithmetic right shift lost the sign");
        end
    end
endmodule

// File: rtl/alu8_bcd.sv
module alu8_bcd
    import alu8_pkg::*;
(
    input  logic [DW-1:0] lhs_i,
    input  logic [DW-1:0] rhs_i,
    output alu_res_t      res_o
);
    logic [PW-1:0] packed_d;
    logic [PW-1:0] acc_d;
    logic          all_valid;

    always_comb begin
        packed_d  = {rhs_i, lhs_i};
        acc_d     = '0;
        all_valid = 1'b1;
        for (int i = NDIG - 1; i >= 0; i--) begin
            acc_d = acc_d * PW'(10) + PW'(packed_d[4*i +: 4]);
            if (packed_d[4*i +: 4] > 4'd9) all_valid = 1'b0;
        end
        res_o = '0;
        {res_o.hi, res_o.lo} = acc_d;

        if (!$isunknown(packed_d) && all_valid)
            assert_bcd_range_R8: assert (acc_d <= PW'(9999))
                else $error("valid decimal digits converted beyond 9999");
    end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
(
    input  logic [DW-1:0] lo_i,
    input  logic [DW-1:0] hi_i,
    input  logic          carry_i,
    input  logic          ovf_i,
    output logic          zero_o,
    output logic          any_o,
    output logic          pal_o,
    output logic          prime_o
);
    function automatic logic byte_is_prime(input logic [DW-1:0] v);
        logic r;
        r = (v >= DW'(2));
        for (int d = 2; d < 16; d++)
            if ((v != DW'(d)) && ((v % DW'(d)) == '0)) r = 1'b0;
        return r;
    endfunction

    logic [DW-1:0] rev_d;

    always_comb begin
        for (int i = 0; i < DW; i++) rev_d[i] = lo_i[DW-1-i];
        zero_o  = ({hi_i, lo_i} == '0);
        any_o   = zero_o | carry_i | ovf_i;
        pal_o   = (rev_d == lo_i);
        prime_o = byte_is_prime(lo_i);

        if (!$isunknown({lo_i, hi_i})) begin
            assert_prime_odd_R14: assert (!prime_o || lo_i == DW'(2) || lo_i[0])
                else $error("even value above two flagged prime");
            assert_pal_ends_R13: assert (!pal_o || (lo_i[DW-1] == lo_i[0]))
                else $error("palindrome flag with unequal end bits");
        end
    end
endmodule

// File: rtl/alu8_xflag.sv
module alu8_xflag
    import alu8_pkg::*;
(
    input  logic [7:0] lhs_i,
    input  logic [7:0] rhs_i,
    input  logic       carry_i,
    input  logic [3:0] opcode_i,
    output logic [7:0] lo_o,
    output logic [7:0] hi_o,
    output logic       zero_o,
    output logic       carry_o,
    output logic       ovf_o,
    output logic       any_o,
    output logic       neg_o,
    output logic       pal_o,
    output logic       prime_o
);
    alu_op_e       op;
    logic [DW-1:0] logic_lo;
    alu_res_t      arith_res;
    alu_res_t      shift_res;
    alu_res_t      bcd_res;
    alu_res_t      res_d;

    assign op = alu_op_e'(opcode_i);

    alu8_logic u_logic (.fn_i(opcode_i[1:0]), .lhs_i(lhs_i), .rhs_i(rhs_i), .lo_o(logic_lo));
    alu8_arith u_arith (.op_i(op), .lhs_i(lhs_i), .rhs_i(rhs_i), .carry_i(carry_i), .res_o(arith_res));
    alu8_shift u_shift (.op_i(op), .lhs_i(lhs_i), .carry_i(carry_i), .res_o(shift_res));
    alu8_bcd   u_bcd   (.lhs_i(lhs_i), .rhs_i(rhs_i), .res_o(bcd_res));

    always_comb begin
        res_d = '0;
        case (op)
            OP_AND, OP_OR, OP_XOR, OP_XNOR:                    res_d.lo = logic_lo;
            OP_ADDU, OP_ADDS, OP_ADDC, OP_MULS, OP_MULU, OP_SUBU: res_d = arith_res;
            OP_ROL, OP_RLC, OP_LSR, OP_ASR, OP_LSL:            res_d = shift_res;
            default:                                           res_d = bcd_res;
        endcase

        if (!$isunknown({opcode_i, lhs_i, rhs_i, carry_i})) begin
            if (!(op inside {OP_MULS, OP_MULU, OP_BCD}))
                assert_hi_zero_R9: assert (res_d.hi == '0)
                    else $error("high byte nonzero on single-byte opcode");
            if (!(op inside {OP_ADDS, OP_MULS}))
                assert_ovf_scope_R11: assert (!res_d.ovf)
                    else $error("overflow raised outside signed opcodes");
        end
    end

    alu8_flags u_flags (
        .lo_i(res_d.lo), .hi_i(res_d.hi), .carry_i(res_d.carry), .ovf_i(res_d.ovf),
        .zero_o(zero_o), .any_o(any_o), .pal_o(pal_o), .prime_o(prime_o)
    );

    assign lo_o    = res_d.lo;
    assign hi_o    = res_d.hi;
    assign carry_o = res_d.carry;
    assign ovf_o   = res_d.ovf;
    assign neg_o   = res_d.neg;
endmodule

// File: tb/alu8_xflag_tb.sv
module alu8_xflag_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] lhs = '0, rhs = '0;
    logic       cin = 1'b0;
    logic [3:0] opc = '0;
    logic [7:0] lo, hi;
    logic       zf, cf, vf, af, nf, pf, prf;
    int         n_cmp = 0, n_bad = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    alu8_xflag u_dut (
        .lhs_i(lhs), .rhs_i(rhs), .carry_i(cin), .opcode_i(opc),
        .lo_o(lo), .hi_o(hi), .zero_o(zf), .carry_o(cf), .ovf_o(vf),
        .any_o(af), .neg_o(nf), .pal_o(pf), .prime_o(prf)
    );

    typedef struct {
        logic [7:0] lo, hi;
        logic z, c, v, f, n, p, pr;
        int   tag;
        logic [3:0] op;
    } exp_t;

    exp_t sb_q[$];

    function automatic string tag_name(int t);
        case (t)
            1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
            5: return "R5";  6: return "R6";  7: return "R7";  default: return "R8";
        endcase
    endfunction

    function automatic exp_t model(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic ci);
        exp_t e;
        int ua = a, ub = b, sa = $signed(a), sb = $signed(b), r;
        logic [15:0] w = '0;
        e = '{lo: 8'h0, hi: 8'h0, z: 0, c: 0, v: 0, f: 0, n: 0, p: 0, pr: 0, tag: 1, op: op};
        case (op)
            4'h0: w = 16'(a & b);        // R1
            4'h1: w = 16'(a | b);
            4'h2: w = 16'(a ^ b);
            4'h3: w = 16'(8'(~(a ^ b)));
            4'h4, 4'h6: begin            // R2
                r = ua + ub + ((op == 4'h6) ? int'(ci) : 0);
                w = 16'(r % 256); e.c = (r > 255); e.tag = 2;
            end
            4'h5: begin                  // R3
                r = sa + sb; w = 16'(r[7:0]); e.v = (r > 127 || r < -128);
                e.n = w[7]; e.tag = 3;
            end
            4'h9: begin                  // R4
                r = ua - ub; w = 16'(r[7:0]); e.c = (ua < ub); e.tag = 4;
            end
            4'h8: begin r = ua * ub; w = r[15:0]; e.tag = 5; end   // R5
            4'h7: begin
                r = sa * sb; w = r[15:0]; e.v = (r > 127 || r < -128);
                e.n = (r < 0); e.tag = 5;
            end
            4'hA: begin w = 16'((ua * 2) % 256 + ua / 128); e.tag = 6; end  // R6
            4'hB: begin w = 16'((ua * 2) % 256 + int'(ci)); e.c = a[7]; e.tag = 6; end
            4'hC: begin w = 16'(ua / 2); e.c = a[0]; e.tag = 7; end         // R7
            4'hD: begin r = sa >>> 1; w = 16'(r[7:0]); e.c = a[0]; e.n = w[7]; e.tag = 7; end
            4'hE: begin w = 16'((ua * 2) % 256); e.c = a[7]; e.tag = 7; end
            default: begin               // R8
                r = (ub / 16) * 1000 + (ub % 16) * 100 + (ua / 16) * 10 + (ua % 16);
                w = r[15:0]; e.tag = 8;
            end
        endcase
        e.lo = w[7:0];
        e.hi = w[15:8];
        e.z  = (w == 16'h0);             // R10
        e.f  = e.z | e.c | e.v;          // R12
        e.p  = 1'b1;                     // R13
        for (int i = 0; i < 8; i++) if (e.lo[i] != e.lo[7-i]) e.p = 1'b0;
        e.pr = (e.lo >= 2);              // R14
        for (int d = 2; d < int'(e.lo); d++) if (int'(e.lo) % d == 0) e.pr = 1'b0;
        return e;
    endfunction

    task automatic drive(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic ci);
        @(posedge clk);
        opc = op; lhs = a; rhs = b; cin = ci;
        sb_q.push_back(model(op, a, b, ci));
    endtask

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (op %0h lhs %0h rhs %0h cin %0b)",
                     req, what, act, expv, opc, lhs, rhs, cin);
        end
    endtask

    // Monitor: results are combinational, so each item is due at the falling edge after its drive
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                string t;
                e = sb_q.pop_front();
                t = tag_name(e.tag);
                chk(lo == e.lo, t, "lo", lo, e.lo);
                chk(hi == e.hi, (e.tag == 5 || e.tag == 8) ? t : "R9", "hi", hi, e.hi);
                chk(cf == e.c, {t, "/R11"}, "carry", cf, e.c);
                chk(vf == e.v, {t, "/R11"}, "ovf", vf, e.v);
                chk(nf == e.n, {t, "/R11"}, "neg", nf, e.n);
                chk(zf == e.z, "R10", "zero", zf, e.z);
                chk(af == e.f, "R12", "any", af, e.f);
                chk(pf == e.p, "R13", "pal", pf, e.p);
                chk(prf == e.pr, "R14", "prime", prf, e.pr);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        drive(4'h0, 8'h00, 8'h00, 1'b0);      // quiet state: zero, palindrome
        // R1 logic
        drive(4'h0, 8'hF0, 8'h3C, 1'b0);
        drive(4'h1, 8'hF0, 8'h0F, 1'b0);
        drive(4'h2, 8'hAA, 8'hAA, 1'b1);
        drive(4'h3, 8'h5A, 8'h0F, 1'b0);
        // R2 add and add with carry
        drive(4'h4, 8'd200, 8'd100, 1'b1);
        drive(4'h6, 8'hFF, 8'h00, 1'b1);
        drive(4'h6, 8'h10, 8'h20, 1'b0);
        // R3 signed add overflow both directions
        drive(4'h5, 8'h7F, 8'h01, 1'b1);
        drive(4'h5, 8'h80, 8'h80, 1'b0);
        drive(4'h5, 8'hFF, 8'h01, 1'b0);
        // R4 subtract, borrow and equal
        drive(4'h9, 8'd3, 8'd5, 1'b0);
        drive(4'h9, 8'd5, 8'd5, 1'b0);
        // R5 multiplies
        drive(4'h8, 8'hFF, 8'hFF, 1'b0);
        drive(4'h7, 8'h80, 8'h80, 1'b0);
        drive(4'h7, 8'hFF, 8'h02, 1'b0);
        drive(4'h7, 8'h00, 8'h9C, 1'b0);
        // R6 rotates
        drive(4'hA, 8'h81, 8'h00, 1'b1);
        drive(4'hB, 8'h80, 8'h00, 1'b1);
        // R7 shifts
        drive(4'hC, 8'h01, 8'h00, 1'b0);
        drive(4'hD, 8'h81, 8'h00, 1'b0);
        drive(4'hE, 8'h80, 8'h00, 1'b0);
        // R8 decimal conversion, valid maximum and invalid digits
        drive(4'hF, 8'h99, 8'h99, 1'b0);
        drive(4'hF, 8'hFF, 8'hFF, 1'b0);
        drive(4'hF, 8'h00, 8'h00, 1'b0);
        // R13 R14 exhaustive over every byte value
        for (int v = 0; v < 256; v++) drive(4'h1, 8'(v), 8'h00, 1'b0);
        // every opcode with random operands
        for (int k = 0; k < 3000; k++)
            drive(4'(k % 16), 8'($urandom), 8'($urandom), 1'($urandom));
        repeat (3) @(posedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule